// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sequences erase and program operations on an on-chip, non-volatile half-word array. The array is split into equal pages, and 16-bit half-words are the unit of programming. A small register interface gives software three things: a command register holding the operation-select bits and a lock bit, an address register naming a page for a page erase, and a status register with a busy bit, sticky error flags and a sticky completion flag. Software picks an erase kind and fires it with a separate go bit in the same write. Programming has no go bit. With program mode selected, a write on the half-word port starts the operation by itself.

Every command first passes an admission gate. The gate refuses any operation that touches a write-protected page group. It also refuses any program aimed at a word that is not erased, unless the data is all zeros. A refused command raises its error flag and never makes the block busy. An admitted command walks through the words it covers, one per cycle, and then holds busy for a configurable settling latency. Reads of the array during that time are stalled.

The unlock sequence is done outside this block and arrives as a level input. A rising edge on that input also clears the lock bit.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset the command register (select 0), address register (select 1) and status register (select 2) read 0, busy_o is low and rd_valid is low.
- R2: Writes to the command and address registers take effect only while unlock_i is high and the lock bit (command bit 4) is clear. Writing 1 to bit 4 sets the lock. A rising edge of unlock_i clears it.
- R3: Writing the command register with bulk-erase (bit 2) and go (bit 3) set erases every word to 0xFFFF. busy_o is then high for DEPTH + OP_LAT cycles. When no protect bit is set, erase takes priority over program mode in the same write.
- R4: Writing page-erase (bit 1) with go sets to 0xFFFF exactly the page that holds the address register's word. busy_o is then high for PAGE_WORDS + OP_LAT cycles. All other words keep their values.
- R5: With program mode (command bit 0) set, a half-word port write stores hw_wdata at hw_addr with no go bit. busy_o is high for 1 + OP_LAT cycles.
- R6: A program to a word that does not read 0xFFFF is refused unless the data is 0x0000. A refused program sets the program-error flag (status bit 1), leaves the word unchanged and does not raise busy_o.
- R7: Protect bit g covers pages 4g to 4g+3. A program or page erase aimed at a covered page is refused. It sets the protect-error flag (status bit 2), changes no word and does not raise busy_o.
- R8: A bulk erase is refused with the protect-error flag if any protect bit is set.
- R9: While busy_o is high, command writes, address writes and half-word port writes are ignored.
- R10: The completion flag (status bit 3) is set in the cycle busy_o falls. All three flags are sticky, and writing 1 to a flag's bit in the status register clears it. Status bit 0 mirrors busy_o.
- R11: A read request while busy_o is high raises rd_stall and returns no data. Once busy_o is low, rd_valid and rd_data arrive one cycle after the request is taken.
- R12: A go bit written with neither erase bit set starts nothing and changes no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unlock_i | input | 1 | Level from the external unlock logic |
| prot_i | input | PAGES/4 | Protect bits, one per group of four pages |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 address, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_sel (combinational) |
| hw_wr | input | 1 | Half-word program strobe |
| hw_addr | input | AW | Half-word program address |
| hw_wdata | input | 16 | Half-word program data |
| rd_req | input | 1 | Array read request, held until rd_valid |
| rd_addr | input | AW | Array read address |
| rd_stall | output | 1 | Read request is held off by a busy operation |
| rd_valid | output | 1 | rd_data carries the requested word |
| rd_data | output | 16 | Array read data |
| busy_o | output | 1 | An operation is in progress |

## Verification
An admitted command raises busy_o at the clock edge that captures the write. busy_o stays high for exactly walk length plus OP_LAT edges, where the walk length is 1, PAGE_WORDS or DEPTH. The bench counts busy cycles at falling edges from the first falling edge after the command. A refused command shows its flag, with busy_o low, at that same first falling edge. The completion flag is read once busy_o has been seen low. Array reads are sampled at the falling edge after the taking edge, and every word is compared with a model array that the bench updates from the requirements alone.

// File: rtl/flash_seq_pkg.sv
// Shared constants and types for the flash program/erase sequencer.
// Assumes 16-bit half-words and a 16-bit register data path.
package flash_seq_pkg;

    localparam int HW = 16;
    localparam int CW = 5;

    // Command register bit positions.
    localparam int CB_PROG = 0;
    localparam int CB_PAGE = 1;
    localparam int CB_BULK = 2;
    localparam int CB_GO   = 3;
    localparam int CB_LOCK = 4;

    // Status register bit positions.
    localparam int SB_BUSY = 0;
    localparam int SB_PERR = 1;
    localparam int SB_PROT = 2;
    localparam int SB_DONE = 3;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    localparam logic [HW-1:0] ERASED_HW = 16'hFFFF;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WALK = 2'd1,
        ENG_HOLD = 2'd2
    } eng_state_e;

endpackage

// File: rtl/flash_regs.sv
// Register file and command decode for the sequencer.
// Holds the command, address and sticky status flags, and turns register
// and half-word port writes into one-cycle command pulses.
// Assumes AW <= 16 and that busy comes from the operation engine.
module flash_regs
    import flash_seq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unlock_i,
    input  logic          busy,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [HW-1:0] reg_wdata,
    input  logic          hw_wr,
    input  logic          set_perr,
    input  logic          set_prot,
    input  logic          set_done,
    output logic [CW-1:0] ctrl_q,
    output logic [AW-1:0] addr_q,
    output logic [3:1]    flags_q,
    output logic          go_bulk,
    output logic          go_page,
    output logic          prog_go,
    output logic [HW-1:0] reg_rdata
);

    logic unlock_q;
    logic unlock_rise;
    logic access_ok;
    logic ctrl_wr;
    logic addr_wr;
    logic stat_wr;

    assign unlock_rise = unlock_i & ~unlock_q;
    assign access_ok   = unlock_i & ~ctrl_q[CB_LOCK] & ~busy;
    assign ctrl_wr     = reg_wr && (reg_sel == SEL_CTRL) && access_ok;
    assign addr_wr     = reg_wr && (reg_sel == SEL_ADDR) && access_ok;
    assign stat_wr     = reg_wr && (reg_sel == SEL_STAT);

    assign go_bulk = ctrl_wr & reg_wdata[CB_GO] & reg_wdata[CB_BULK];
    assign go_page = ctrl_wr & reg_wdata[CB_GO] & ~reg_wdata[CB_BULK] & reg_wdata[CB_PAGE];
    assign prog_go = hw_wr & ctrl_q[CB_PROG] & access_ok & ~ctrl_wr;

    // Edge detector for the external unlock level.
    always_ff @(posedge clk) begin
        if (!rst_n) unlock_q <= 1'b0;
        else        unlock_q <= unlock_i;
    end

    // Command register; the go bit is never stored, the lock clears on a new unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q        <= reg_wdata[CW-1:0];
            ctrl_q[CB_GO] <= 1'b0;
        end else if (unlock_rise) begin
            ctrl_q[CB_LOCK] <= 1'b0;
        end
    end

    // Page-select address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_wr) addr_q <= reg_wdata[AW-1:0];
    end

    // Sticky flags: a set wins over a write-one-to-clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q[SB_PERR] <= set_perr | (flags_q[SB_PERR] & ~(stat_wr & reg_wdata[SB_PERR]));
            flags_q[SB_PROT] <= set_prot | (flags_q[SB_PROT] & ~(stat_wr & reg_wdata[SB_PROT]));
            flags_q[SB_DONE] <= set_done | (flags_q[SB_DONE] & ~(stat_wr & reg_wdata[SB_DONE]));
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: reg_rdata[CW-1:0] = ctrl_q;
            SEL_ADDR: reg_rdata[AW-1:0] = addr_q;
            SEL_STAT: reg_rdata[3:0]    = {flags_q, busy};
            default:  reg_rdata         = '0;
        endcase
    end

endmodule

// File: rtl/flash_gate.sv
// Admission gate: checks protection and the erased state for each command
// pulse and either launches the engine or raises an error flag.
// Assumes at most one command pulse per cycle, bulk first, then page, then program.
module flash_gate
    import flash_seq_pkg::*;
#(
    parameter int AW     = 10,
    parameter int PWB    = 4,
    parameter int GROUPS = 16
) (
    input  logic              go_bulk,
    input  logic              go_page,
    input  logic              prog_go,
    input  logic [AW-1:0]     page_sel_addr,
    input  logic [AW-1:0]     prog_addr,
    input  logic [HW-1:0]     prog_data,
    input  logic [HW-1:0]     cur_word,
    input  logic [GROUPS-1:0] prot_i,
    output logic              start,
    output logic [AW-1:0]     op_first,
    output logic [AW-1:0]     op_last,
    output logic [HW-1:0]     op_data,
    output logic              set_perr,
    output logic              set_prot
);

    localparam int GB  = PWB + 2;
    localparam int GIW = AW - GB;

    logic [GIW-1:0] page_grp;
    logic [GIW-1:0] prog_grp;
    logic           page_locked;
    logic           prog_locked;
    logic           word_dirty;

    assign page_grp    = page_sel_addr[AW-1:GB];
    assign prog_grp    = prog_addr[AW-1:GB];
    assign page_locked = prot_i[page_grp];
    assign prog_locked = prot_i[prog_grp];
    assign word_dirty  = (cur_word != ERASED_HW) && (prog_data != '0);

    // Command arbitration and refusal decision.
    always_comb begin
        start    = 1'b0;
        op_first = '0;
        op_last  = '0;
        op_data  = ERASED_HW;
        set_perr = 1'b0;
        set_prot = 1'b0;
        if (go_bulk) begin
            if (|prot_i) begin
                set_prot = 1'b1;
            end else begin
                start   = 1'b1;
                op_last = '1;
            end
        end else if (go_page) begin
            if (page_locked) begin
                set_prot = 1'b1;
            end else begin
                start    = 1'b1;
                op_first = {page_sel_addr[AW-1:PWB], {PWB{1'b0}}};
                op_last  = {page_sel_addr[AW-1:PWB], {PWB{1'b1}}};
            end
        end else if (prog_go) begin
            if (prog_locked) begin
                set_prot = 1'b1;
            end else if (word_dirty) begin
                set_perr = 1'b1;
            end else begin
                start    = 1'b1;
                op_first = prog_addr;
                op_last  = prog_addr;
                op_data  = prog_data;
            end
        end
    end

endmodule

// File: rtl/flash_engine.sv
// Operation engine: writes one word per cycle from op_first to op_last,
// then holds busy for OP_LAT settling cycles and pulses done.
// Assumes OP_LAT >= 1 and op_first <= op_last.
module flash_engine
    import flash_seq_pkg::*;
#(
    parameter int AW     = 10,
    parameter int OP_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] op_first,
    input  logic [AW-1:0] op_last,
    input  logic [HW-1:0] op_data,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [HW-1:0] mem_wdata,
    output logic          done_pulse
);

    localparam int LW = $clog2(OP_LAT + 1);

    eng_state_e    state;
    logic [AW-1:0] idx;
    logic [AW-1:0] last_q;
    logic [HW-1:0] data_q;
    logic [LW-1:0] cnt;

    // Walk and settle state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            idx    <= '0;
            last_q <= '0;
            data_q <= '0;
            cnt    <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (start) begin
                    idx    <= op_first;
                    last_q <= op_last;
                    data_q <= op_data;
                    state  <= ENG_WALK;
                end
                ENG_WALK: if (idx == last_q) begin
                    cnt   <= LW'(OP_LAT);
                    state <= ENG_HOLD;
                end else begin
                    idx <= idx + 1'b1;
                end
                ENG_HOLD: if (cnt == LW'(1)) begin
                    state <= ENG_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign busy       = (state != ENG_IDLE);
    assign mem_we     = (state == ENG_WALK);
    assign mem_waddr  = idx;
    assign mem_wdata  = data_q;
    assign done_pulse = (state == ENG_HOLD) && (cnt == LW'(1));

endmodule

// File: rtl/flash_array.sv
// Half-word array model: one write port, one combinational check port
// used by the admission gate, and one registered read port.
// Contents are not reset; software erases before use.
module flash_array
    import flash_seq_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [HW-1:0] wdata,
    input  logic [AW-1:0] chk_addr,
    output logic [HW-1:0] chk_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [HW-1:0] rd_data,
    output logic          rd_valid
);

    localparam int DEPTH = 1 << AW;

    logic [HW-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read data path.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // Read-valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end

    assign chk_data = mem[chk_addr];

endmodule

// File: rtl/flash_pe_seq.sv
// Top of the flash program/erase sequencer: register file, admission gate,
// walking engine and array model. Reads are held off while busy.
// Assumes PAGES and PAGE_WORDS are powers of two, PAGES >= 8, AW <= 16.
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int PAGES      = 64,
    parameter int PAGE_WORDS = 16,
    parameter int OP_LAT     = 4,
    localparam int DEPTH     = PAGES * PAGE_WORDS,
    localparam int AW        = $clog2(DEPTH),
    localparam int PWB       = $clog2(PAGE_WORDS),
    localparam int GROUPS    = PAGES / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock_i,
    input  logic [GROUPS-1:0] prot_i,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HW-1:0]     reg_wdata,
    output logic [HW-1:0]     reg_rdata,
    input  logic              hw_wr,
    input  logic [AW-1:0]     hw_addr,
    input  logic [HW-1:0]     hw_wdata,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_stall,
    output logic              rd_valid,
    output logic [HW-1:0]     rd_data,
    output logic              busy_o
);

    logic [CW-1:0] ctrl_q;
    logic [AW-1:0] addr_q;
    logic [3:1]    flags_q;
    logic          go_bulk, go_page, prog_go;
    logic          start, set_perr, set_prot, done_pulse, refused;
    logic [AW-1:0] op_first, op_last, mem_waddr;
    logic [HW-1:0] op_data, mem_wdata, cur_word;
    logic          mem_we;

    assign rd_stall = rd_req & busy_o;
    assign refused  = set_perr | set_prot;

    flash_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i), .busy(busy_o),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .hw_wr(hw_wr),
        .set_perr(set_perr), .set_prot(set_prot), .set_done(done_pulse),
        .ctrl_q(ctrl_q), .addr_q(addr_q), .flags_q(flags_q),
        .go_bulk(go_bulk), .go_page(go_page), .prog_go(prog_go), .reg_rdata(reg_rdata)
    );

    flash_gate #(.AW(AW), .PWB(PWB), .GROUPS(GROUPS)) u_gate (
        .go_bulk(go_bulk), .go_page(go_page), .prog_go(prog_go),
        .page_sel_addr(addr_q), .prog_addr(hw_addr), .prog_data(hw_wdata),
        .cur_word(cur_word), .prot_i(prot_i),
        .start(start), .op_first(op_first), .op_last(op_last), .op_data(op_data),
        .set_perr(set_perr), .set_prot(set_prot)
    );

    flash_engine #(.AW(AW), .OP_LAT(OP_LAT)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_first(op_first), .op_last(op_last), .op_data(op_data),
        .busy(busy_o), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .done_pulse(done_pulse)
    );

    flash_array #(.AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .chk_addr(hw_addr), .chk_data(cur_word),
        .rd_en(rd_req & ~busy_o), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: rtl/flash_pe_seq_chk.sv
// Property checker for the sequencer, attached by bind.
module flash_pe_seq_chk
    import flash_seq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          rd_valid,
    input logic [CW-1:0] ctrl_q,
    input logic [3:1]    flags_q,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [HW-1:0] reg_wdata,
    input logic          refused
);

    a_r9_ctrl_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctrl_q));

    a_r10_done_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> flags_q[SB_DONE]);

    a_r10_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[SB_PERR] && !(reg_wr && reg_sel == SEL_STAT && reg_wdata[SB_PERR])
        |=> flags_q[SB_PERR]);

    a_r7_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[SB_PROT] && !(reg_wr && reg_sel == SEL_STAT && reg_wdata[SB_PROT])
        |=> flags_q[SB_PROT]);

    a_r11_no_data_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !rd_valid);

    a_r6_refusal_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> !busy_o);

endmodule

bind flash_pe_seq flash_pe_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .rd_valid(rd_valid),
    .ctrl_q(ctrl_q), .flags_q(flags_q), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .refused(refused)
);

// File: tb/flash_pe_seq_tb_top.sv
module flash_pe_seq_tb_top;

    localparam int PAGES = 64;
    localparam int PW    = 16;
    localparam int LAT   = 4;
    localparam int DEPTH = PAGES * PW;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          unlock = 1'b0;
    logic [15:0]   prot = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          hw_wr = 1'b0;
    logic [AW-1:0] hw_addr = '0;
    logic [15:0]   hw_wdata = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_stall, rd_valid, busy;
    logic [15:0]   rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model [DEPTH];

    always #5 clk = ~clk;

    flash_pe_seq #(.PAGES(PAGES), .PAGE_WORDS(PW), .OP_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .unlock_i(unlock), .prot_i(prot),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_wr(hw_wr), .hw_addr(hw_addr), .hw_wdata(hw_wdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_stall(rd_stall),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy_o(busy)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 40503) ^ 4660);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [15:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic prog(input int a, input logic [15:0] d);
        @(negedge clk);
        hw_wr = 1'b1; hw_addr = AW'(a); hw_wdata = d;
        @(negedge clk);
        hw_wr = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy === 1'b1) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd_mem(input int a, output logic [15:0] d);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        while (rd_valid !== 1'b1) @(negedge clk);
        d = rd_data;
        rd_req = 1'b0;
    endtask

    task automatic sweep(input string tag);
        logic [15:0] d;
        for (int i = 0; i < DEPTH; i++) begin
            rd_mem(i, d);
            chk(d === model[i], tag, d, model[i]);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        bit refuse;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_reg(2'd0, v); chk(v == 16'h0, "R1 ctrl", v, 0);
        rd_reg(2'd1, v); chk(v == 16'h0, "R1 addr", v, 0);
        rd_reg(2'd2, v); chk(v == 16'h0, "R1 status", v, 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 busy/valid", {busy, rd_valid}, 0);

        // R2: gating by unlock and lock
        wr_reg(2'd0, 16'h0001);
        rd_reg(2'd0, v); chk(v == 16'h0, "R2 ctrl while locked out", v, 0);
        wr_reg(2'd1, 16'h0055);
        rd_reg(2'd1, v); chk(v == 16'h0, "R2 addr while locked out", v, 0);
        unlock = 1'b1;
        @(negedge clk);
        wr_reg(2'd0, 16'h0001);
        rd_reg(2'd0, v); chk(v == 16'h1, "R2 ctrl unlocked", v, 1);
        wr_reg(2'd0, 16'h0010);
        wr_reg(2'd0, 16'h0001);
        rd_reg(2'd0, v); chk(v == 16'h10, "R2 write after lock", v, 16'h10);
        unlock = 1'b0;
        @(negedge clk);
        unlock = 1'b1;
        @(negedge clk);
        rd_reg(2'd0, v); chk(v == 16'h0, "R2 lock cleared by unlock edge", v, 0);

        // R3: bulk erase
        wr_reg(2'd0, 16'h000C);
        busy_len(n); chk(n == DEPTH + LAT, "R3 bulk busy length", n, DEPTH + LAT);
        rd_reg(2'd2, v); chk(v == 16'h0008, "R10 done after bulk", v, 8);
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        sweep("R3 erased word");
        wr_reg(2'd2, 16'h0008);
        rd_reg(2'd2, v); chk(v == 16'h0, "R10 done cleared", v, 0);

        // R5: program every word
        wr_reg(2'd0, 16'h0001);
        for (int i = 0; i < DEPTH; i++) begin
            prog(i, pat(i));
            busy_len(n); chk(n == 1 + LAT, "R5 program busy length", n, 1 + LAT);
            model[i] = pat(i);
        end
        sweep("R5 programmed word");
        wr_reg(2'd2, 16'h000E);

        // R6: programming a non-erased word
        prog(5, 16'h1111);
        refuse = (model[5] != 16'hFFFF);
        chk(busy == 1'b0, "R6 refused stays idle", busy, 0);
        rd_reg(2'd2, v); chk(v[1] == refuse, "R6 perr flag", v, 2);
        rd_mem(5, v); chk(v == model[5], "R6 word unchanged", v, model[5]);
        wr_reg(2'd2, 16'h0002);
        prog(5, 16'h0000);
        busy_len(n); chk(n == 1 + LAT, "R6 zero write accepted", n, 1 + LAT);
        model[5] = 16'h0;
        rd_mem(5, v); chk(v == 16'h0, "R6 zero stored", v, 0);
        rd_reg(2'd2, v); chk(v == 16'h0008, "R6 no perr on zero", v, 8);
        wr_reg(2'd2, 16'h000E);

        // R4: page erase of page 7 from a mid-page address
        wr_reg(2'd1, 16'(7 * PW + 3));
        wr_reg(2'd0, 16'h000A);
        busy_len(n); chk(n == PW + LAT, "R4 page busy length", n, PW + LAT);
        for (int i = 7 * PW; i < 8 * PW; i++) model[i] = 16'hFFFF;
        sweep("R4 word after page erase");
        wr_reg(2'd2, 16'h000E);

        // R7: protect sweep with group 2 (pages 8..11) protected
        prot = 16'h0004;
        wr_reg(2'd0, 16'h0001);
        for (int p = 0; p < PAGES; p++) begin
            refuse = (p / 4 == 2);
            prog(p * PW + 5, 16'h0000);
            busy_len(n);
            chk(n == (refuse ? 0 : 1 + LAT), "R7 program under protect", n, refuse ? 0 : 1 + LAT);
            rd_reg(2'd2, v);
            chk(v[2] == refuse, "R7 protect flag", v, refuse ? 4 : 8);
            wr_reg(2'd2, 16'h000E);
            if (!refuse) model[p * PW + 5] = 16'h0;
        end
        wr_reg(2'd1, 16'(10 * PW));
        wr_reg(2'd0, 16'h000A);
        chk(busy == 1'b0, "R7 protected page erase idle", busy, 0);
        rd_reg(2'd2, v); chk(v == 16'h0004, "R7 page erase refused flag", v, 4);
        wr_reg(2'd2, 16'h000E);
        wr_reg(2'd1, 16'(12 * PW));
        wr_reg(2'd0, 16'h000A);
        busy_len(n); chk(n == PW + LAT, "R7 unprotected page erase", n, PW + LAT);
        for (int i = 12 * PW; i < 13 * PW; i++) model[i] = 16'hFFFF;
        sweep("R7 word after protect tests");
        wr_reg(2'd2, 16'h000E);

        // R8: bulk erase refused while any protect bit set
        wr_reg(2'd0, 16'h000C);
        chk(busy == 1'b0, "R8 bulk refused idle", busy, 0);
        rd_reg(2'd2, v); chk(v == 16'h0004, "R8 protect flag", v, 4);
        rd_mem(0, v); chk(v == model[0], "R8 word 0 unchanged", v, model[0]);
        wr_reg(2'd2, 16'h000E);

        // R12: go with no erase kind
        wr_reg(2'd0, 16'h0008);
        chk(busy == 1'b0, "R12 no operation started", busy, 0);
        rd_reg(2'd2, v); chk(v == 16'h0, "R12 no flag change", v, 0);

        // R9 / R11: commands and reads during a bulk erase
        prot = 16'h0000;
        wr_reg(2'd1, 16'h0021);
        wr_reg(2'd0, 16'h000D);
        chk(busy == 1'b1, "R3 erase wins over program mode", busy, 1);
        prog(3, 16'h0000);
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, 16'h0077);
        rd_reg(2'd0, v); chk(v == 16'h0005, "R9 ctrl unchanged while busy", v, 5);
        rd_reg(2'd1, v); chk(v == 16'h0021, "R9 addr unchanged while busy", v, 16'h21);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(3);
        #1;
        chk(rd_stall == 1'b1, "R11 stall while busy", rd_stall, 1);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11 no data while busy", rd_valid, 0);
        while (rd_valid !== 1'b1) @(negedge clk);
        chk(busy == 1'b0, "R11 data only after busy", busy, 0);
        chk(rd_data == 16'hFFFF, "R9 program during erase ignored", rd_data, 16'hFFFF);
        rd_req = 1'b0;
        rd_reg(2'd2, v); chk(v == 16'h0008, "R10 done after final erase", v, 8);
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        sweep("R3 final erased word");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule